// File: doc/BRIEF.md
# Dual-Channel Fractional Clock Divider

The block derives two divided clocks from one fast input clock. Each channel divides by an integer from 2 to 63 plus a 16-bit binary fraction. The average ratio is reached by stretching some output periods by one input cycle. A 16-bit phase accumulator decides which periods are stretched. All settings arrive as parallel inputs that are held steady by surrounding logic.

Channel A takes its ratio from one of three preset banks. A two-bit pin code picks the bank. Channel B has a single ratio of its own.

Each channel also has three controls:
- an integer-only mode that ignores the fraction,
- a bypass that toggles the output on every input clock,
- an output enable that holds the output low.

Ratio changes are picked up only where one output period ends and the next begins. This keeps truncated pulses off the output.

Top module: `dual_frac_divider`

## Requirements
- R1: With `a_sel` = 0, 1 or 2, channel A divides using bank 0, 1 or 2 respectively of `a_int_bank`/`a_frac_bank`.
- R2: The reserved code `a_sel` = 3 makes channel A use bank 0.
- R3: Channel B always uses `b_int`/`b_frac`, whatever `a_sel` is.
- R4: In fractional mode, every output period adds the 16-bit fraction to a 16-bit accumulator. A period lasts integer+1 input cycles when that addition carries out of bit 15, and integer cycles otherwise.
- R5: With the integer-mode input high, the period is exactly the integer value and the fraction has no effect. The accumulator holds its value.
- R6: An integer setting of 0 or 1 is treated as 2.
- R7: An output is high for the first floor(L/2) input cycles of a period of length L, and low for the rest.
- R8: Bank select, integer and fraction values are sampled only at the first cycle of a new output period. A change in mid-period leaves the running period unchanged.
- R9: With bypass high and the output enabled, the output inverts on every input clock edge (half the input rate), whatever the ratio settings are.
- R10: With the enable input low, the output is 0 from the next clock edge on. With it high, the output follows the divider.
- R11: While `rst_n` is low, both outputs are 0 and the accumulators are cleared. The first output period begins on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock driving both channels |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 2 | Channel A bank code (3 = reserved, acts as 0) |
| a_int_bank | input | 3x6 | Channel A integer ratio per bank |
| a_frac_bank | input | 3x16 | Channel A fractional ratio per bank |
| b_int | input | 6 | Channel B integer ratio |
| b_frac | input | 16 | Channel B fractional ratio |
| a_int_mode | input | 1 | Channel A ignores its fraction when high |
| b_int_mode | input | 1 | Channel B ignores its fraction when high |
| a_bypass | input | 1 | Channel A toggles each input clock when high |
| b_bypass | input | 1 | Channel B toggles each input clock when high |
| a_oe | input | 1 | Channel A output enable (0 = held low) |
| b_oe | input | 1 | Channel B output enable (0 = held low) |
| a_clk_o | output | 1 | Channel A divided clock |
| b_clk_o | output | 1 | Channel B divided clock |

## Verification
Some properties are checked on every cycle by assertions inside each channel:
- the phase counter stays inside the current period,
- the period length stays frozen between boundaries,
- a stretched period is never more than one cycle longer than the clamped integer,
- a disabled output is low,
- bypass gives a strict toggle.

Other behaviour only shows up in the bench's scenarios, where a behavioural model is compared against the outputs on every clock:
- bank selection, including the reserved code,
- channel B ignoring the select code,
- the exact sequence of stretched periods for a given fraction,
- the duty split for odd lengths,
- the timing of mid-period setting changes.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    typedef enum logic [1:0] {
        BANK_0    = 2'd0,
        BANK_1    = 2'd1,
        BANK_2    = 2'd2,
        BANK_RSVD = 2'd3
    } bank_code_e;

    localparam int unsigned MIN_RATIO = 2;

endpackage

// File: rtl/frac_bank_mux.sv
module frac_bank_mux
    import frac_div_pkg::*;
#(
    parameter int unsigned INT_W  = 6,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned BANKS  = 3
) (
    input  logic [1:0]                   sel_i,
    input  logic [BANKS-1:0][INT_W-1:0]  int_bank_i,
    input  logic [BANKS-1:0][FRAC_W-1:0] frac_bank_i,
    output logic [INT_W-1:0]             int_o,
    output logic [FRAC_W-1:0]            frac_o
);

    bank_code_e code;

    always_comb begin
        code   = bank_code_e'(sel_i);
        int_o  = int_bank_i[0];
        frac_o = frac_bank_i[0];
        unique case (code)
            BANK_1: begin
                int_o  = int_bank_i[1];
                frac_o = frac_bank_i[1];
            end
            BANK_2: begin
                int_o  = int_bank_i[2];
                frac_o = frac_bank_i[2];
            end
            default: begin
                // codes 0 and the reserved 3 both land on bank 0 (R1, R2)
                int_o  = int_bank_i[0];
                frac_o = frac_bank_i[0];
            end
        endcase
    end

endmodule

// File: rtl/frac_div_channel.sv
module frac_div_channel
    import frac_div_pkg::*;
#(
    parameter int unsigned INT_W  = 6,
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              int_mode_i,
    input  logic              bypass_i,
    input  logic              oe_i,
    output logic              clk_o
);

    localparam int unsigned CW = INT_W + 1;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     len;
        logic [FRAC_W-1:0] acc;
        logic              tog;
        logic              out;
    } chan_t;

    chan_t         st_d, st_q;
    logic [CW-1:0] base_len;
    logic          at_end;
    logic [FRAC_W:0] sum;

    always_comb begin
        st_d     = st_q;
        base_len = (int_i < INT_W'(MIN_RATIO)) ? CW'(MIN_RATIO) : {1'b0, int_i};
        at_end   = (st_q.cnt == st_q.len - 1'b1);
        sum      = {1'b0, st_q.acc} + {1'b0, frac_i};
        if (at_end) begin
            st_d.cnt = '0;
            if (int_mode_i) begin
                st_d.len = base_len;
            end else begin
                st_d.len = base_len + CW'(sum[FRAC_W]);
                st_d.acc = sum[FRAC_W-1:0];
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.tog = ~st_q.tog;
        if (!oe_i)
            st_d.out = 1'b0;
        else if (bypass_i)
            st_d.out = st_d.tog;
        else
            st_d.out = (st_d.cnt < (st_d.len >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(1);
            st_q.len <= CW'(MIN_RATIO);
            st_q.acc <= '0;
            st_q.tog <= 1'b0;
            st_q.out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.out;

    // R7: phase counter never leaves the current period
    p_cnt_in_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.len);

    // R8: period length only changes across a boundary
    p_len_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !at_end |=> $stable(st_q.len));

    // R4: a new period is the clamped integer or one cycle more
    p_stretch_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !int_mode_i) |=>
            (st_q.len >= $past(base_len)) && (st_q.len <= $past(base_len) + 1'b1));

    // R5: integer mode loads exactly the clamped integer
    p_int_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && int_mode_i) |=> (st_q.len == $past(base_len)) && $stable(st_q.acc));

    // R6: no period shorter than the minimum ratio
    p_min_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len >= CW'(MIN_RATIO));

    // R10: disabled output is held low
    p_oe_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |=> !clk_o);

    // R9: bypass with enable toggles each edge
    p_bypass_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i && oe_i && $past(bypass_i && oe_i)) |=> (clk_o != $past(clk_o)));

endmodule

// File: rtl/dual_frac_divider.sv
module dual_frac_divider
    import frac_div_pkg::*;
#(
    parameter int unsigned INT_W  = 6,
    parameter int unsigned FRAC_W = 16,
    parameter int unsigned BANKS  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   a_sel,
    input  logic [BANKS-1:0][INT_W-1:0]  a_int_bank,
    input  logic [BANKS-1:0][FRAC_W-1:0] a_frac_bank,
    input  logic [INT_W-1:0]             b_int,
    input  logic [FRAC_W-1:0]            b_frac,
    input  logic                         a_int_mode,
    input  logic                         b_int_mode,
    input  logic                         a_bypass,
    input  logic                         b_bypass,
    input  logic                         a_oe,
    input  logic                         b_oe,
    output logic                         a_clk_o,
    output logic                         b_clk_o
);

    localparam int unsigned NCH = 2;

    logic [INT_W-1:0]          a_int_sel;
    logic [FRAC_W-1:0]         a_frac_sel;
    logic [NCH-1:0][INT_W-1:0]  ch_int;
    logic [NCH-1:0][FRAC_W-1:0] ch_frac;
    logic [NCH-1:0]             ch_imode, ch_byp, ch_oe, ch_out;

    frac_bank_mux #(.INT_W(INT_W), .FRAC_W(FRAC_W), .BANKS(BANKS)) u_bank (
        .sel_i       (a_sel),
        .int_bank_i  (a_int_bank),
        .frac_bank_i (a_frac_bank),
        .int_o       (a_int_sel),
        .frac_o      (a_frac_sel)
    );

    assign ch_int   = {b_int, a_int_sel};
    assign ch_frac  = {b_frac, a_frac_sel};
    assign ch_imode = {b_int_mode, a_int_mode};
    assign ch_byp   = {b_bypass, a_bypass};
    assign ch_oe    = {b_oe, a_oe};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        frac_div_channel #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .int_i      (ch_int[g]),
            .frac_i     (ch_frac[g]),
            .int_mode_i (ch_imode[g]),
            .bypass_i   (ch_byp[g]),
            .oe_i       (ch_oe[g]),
            .clk_o      (ch_out[g])
        );
    end

    assign a_clk_o = ch_out[0];
    assign b_clk_o = ch_out[1];

endmodule

// File: tb/tb_dual_frac_divider.sv
`timescale 1ns/1ps
module tb_dual_frac_divider;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       a_sel = '0;
    logic [2:0][5:0]  a_int_bank = '0;
    logic [2:0][15:0] a_frac_bank = '0;
    logic [5:0]       b_int = 6'd4;
    logic [15:0]      b_frac = '0;
    logic a_int_mode = 0, b_int_mode = 0, a_bypass = 0, b_bypass = 0, a_oe = 0, b_oe = 0;
    logic a_clk_o, b_clk_o;

    int n_chk = 0, n_fail = 0;
    string tag_a = "R11", tag_b = "R11";
    bit compare_on = 0;

    // behavioural reference, index 0 = channel A, 1 = channel B
    int pos[2], plen[2], acc[2], mout[2];
    bit tgl[2];

    always #2.5 clk = ~clk;

    dual_frac_divider dut (
        .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .a_int_bank(a_int_bank),
        .a_frac_bank(a_frac_bank), .b_int(b_int), .b_frac(b_frac),
        .a_int_mode(a_int_mode), .b_int_mode(b_int_mode),
        .a_bypass(a_bypass), .b_bypass(b_bypass), .a_oe(a_oe), .b_oe(b_oe),
        .a_clk_o(a_clk_o), .b_clk_o(b_clk_o)
    );

    task automatic step_model(int c, int iv, int fv, bit im, bit by, bit oe);
        int eff;
        eff = (iv < 2) ? 2 : iv;
        pos[c] = pos[c] + 1;
        if (pos[c] >= plen[c]) begin
            pos[c] = 0;
            if (im) plen[c] = eff;
            else begin
                acc[c] = acc[c] + fv;
                plen[c] = eff + ((acc[c] >= 65536) ? 1 : 0);
                acc[c] = acc[c] % 65536;
            end
        end
        tgl[c] = !tgl[c];
        if (!oe) mout[c] = 0;
        else if (by) mout[c] = tgl[c];
        else mout[c] = (pos[c] < plen[c] / 2) ? 1 : 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                pos[c] = 0; plen[c] = 1; acc[c] = 0; tgl[c] = 0; mout[c] = 0;
            end
        end else begin
            int bi;
            bi = (a_sel == 2'd1) ? 1 : (a_sel == 2'd2) ? 2 : 0;
            step_model(0, a_int_bank[bi], a_frac_bank[bi], a_int_mode, a_bypass, a_oe);
            step_model(1, b_int, b_frac, b_int_mode, b_bypass, b_oe);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && compare_on) begin
            check(tag_a, "a_clk_o", a_clk_o, mout[0]);
            check(tag_b, "b_clk_o", b_clk_o, mout[1]);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        a_int_bank  = {6'd9, 6'd7, 6'd4};
        a_frac_bank = {16'h0000, 16'h8000, 16'h4000};
        run(4);
        // R11: outputs low while reset is held
        check("R11", "a_clk_o in reset", a_clk_o, 0);
        check("R11", "b_clk_o in reset", b_clk_o, 0);
        a_oe = 1; b_oe = 1;
        run(3);
        check("R11", "a_clk_o in reset with oe", a_clk_o, 0);
        a_oe = 0; b_oe = 0;
        rst_n = 1;
        compare_on = 1;
        tag_a = "R10"; tag_b = "R10";
        run(40);
        check("R10", "a_clk_o disabled", a_clk_o, 0);
        a_oe = 1; b_oe = 1;
        b_frac = 16'h2000;
        // R1: banks 0..2, fractional
        tag_b = "R3";
        for (int s = 0; s < 3; s++) begin
            a_sel = 2'(s);
            tag_a = "R1";
            run(300);
        end
        // R2: reserved code
        tag_a = "R2"; a_sel = 2'd3;
        run(300);
        // R4: accumulator patterns incl. near-full fraction
        tag_a = "R4"; a_sel = 2'd0;
        a_frac_bank[0] = 16'hFFFF; a_int_bank[0] = 6'd3;
        b_int = 6'd5; b_frac = 16'h5555;
        run(400);
        a_frac_bank[0] = 16'h0001;
        run(200);
        // R5: integer mode ignores fraction
        tag_a = "R5"; tag_b = "R5";
        a_int_mode = 1; b_int_mode = 1; a_frac_bank[0] = 16'hC000;
        run(200);
        a_int_mode = 0; b_int_mode = 0;
        // R6: clamp of 0 and 1
        tag_a = "R6"; tag_b = "R6";
        a_int_bank[0] = 6'd1; b_int = 6'd0; a_frac_bank[0] = 16'h0; b_frac = 16'h0;
        run(100);
        // R7: odd lengths give floor(L/2) high
        tag_a = "R7"; tag_b = "R7";
        a_int_bank[0] = 6'd7; b_int = 6'd63; b_int_mode = 1; a_int_mode = 1;
        run(300);
        b_int_mode = 0; a_int_mode = 0;
        // R8: settings changed mid-period
        tag_a = "R8"; tag_b = "R8";
        for (int k = 0; k < 40; k++) begin
            a_sel = 2'(k % 4);
            a_int_bank[k % 3] = 6'(3 + (k * 5) % 11);
            b_int = 6'(2 + (k * 3) % 13);
            b_frac = 16'(k * 4099);
            run(7);
        end
        // R9: bypass with odd settings
        tag_a = "R9"; tag_b = "R9";
        a_bypass = 1; b_bypass = 1;
        run(60);
        check("R9", "a toggles", a_clk_o, mout[0]);
        // R10: enable dropped while in bypass, then divider
        tag_a = "R10"; tag_b = "R10";
        a_oe = 0;
        run(30);
        check("R10", "a_clk_o disabled in bypass", a_clk_o, 0);
        a_bypass = 0; b_bypass = 0; a_oe = 1;
        run(100);
        // R11: reset mid-run clears accumulators
        tag_a = "R11"; tag_b = "R11";
        compare_on = 0;
        rst_n = 0;
        run(3);
        check("R11", "a_clk_o after re-reset", a_clk_o, 0);
        check("R11", "b_clk_o after re-reset", b_clk_o, 0);
        rst_n = 1; compare_on = 1;
        run(300);
        compare_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule